// File: doc/BRIEF.md
# Mesh Node Physical Address Mapper

This block turns a memory request issued by one node of a 4x4 mesh into a physical address in a 17 kB main memory. The memory holds sixteen private 1 kB slots, one per node, and one 1 kB area that every node can reach. Each node works in its own 2 kB window. The lower kilobyte of that window is its private slot and the upper kilobyte is the common area.

A request carries a 4-bit node number and a node-local address. The node number is the node's mesh column (X, upper two bits) followed by its row (Y, lower two bits). X picks a 4 kB block of the private memory and Y picks the 1 kB slot inside it. The block builds the private and the common candidate addresses side by side. Bit 10 of the local address then chooses one of them. Local addresses wider than the 2 kB window are refused with an error pulse. Results appear one clock after the request.

Top module: `node_addr_map`

## Requirements
- R1: While `rst_n` is low, `resp_valid`, `resp_err` and `resp_shared` are 0 and `resp_paddr` is 0.
- R2: A request with `req_valid` = 1 and `req_addr[15:11]` all zero gives `resp_valid` = 1 on the next clock edge. A cycle with `req_valid` = 0 gives `resp_valid` = 0 and `resp_err` = 0 on the next edge.
- R3: When `req_addr[10]` = 0, the result is private. `resp_paddr` = X*4096 + Y*1024 + `req_addr[9:0]`, where X = `req_node[3:2]` and Y = `req_node[1:0]`, and `resp_shared` = 0. This covers the range 0 to 16383.
- R4: When `req_addr[10]` = 1, the result is common. `resp_paddr` = 16384 + `req_addr[9:0]` for every node number, and `resp_shared` = 1.
- R5: A request with any of `req_addr[15:11]` set gives `resp_err` = 1 and `resp_valid` = 0 on the next edge.
- R6: After an idle cycle or a refused request, `resp_paddr` and `resp_shared` keep the value of the last accepted result.
- R7: `resp_valid` and `resp_err` are never 1 together, and a valid `resp_paddr` never exceeds 17407.
- R8: Requests may come on consecutive cycles, and each one yields its own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_node | input | 4 | Requesting node: {X[1:0], Y[1:0]} |
| req_addr | input | 16 | Node-local byte address |
| resp_valid | output | 1 | Mapped address available |
| resp_paddr | output | 15 | Physical address in main memory |
| resp_shared | output | 1 | Result lies in the common area |
| resp_err | output | 1 | Request refused: address outside the 2 kB window |

## Verification
The assertions check the following on every cycle:
- the one-cycle link from request to `resp_valid` or `resp_err`;
- that the two never coincide;
- that `resp_shared` follows bit 10 of the previous request;
- that private results stay below 16384 and common results stay in 16384 to 17407;
- that the address holds steady when no valid result is shown.

Only the bench's scenarios can show the exact arithmetic for each node column and row. The same holds for the value that is held across a refused request, back-to-back throughput, and the return to the reset state in the middle of traffic.

// File: rtl/node_addr_map.sv
module node_addr_map #(
  parameter int X_BITS    = 2,
  parameter int Y_BITS    = 2,
  parameter int SLOT_BITS = 10,
  parameter int REQ_AW    = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  input  logic [X_BITS+Y_BITS-1:0]                   req_node,
  input  logic [REQ_AW-1:0]                          req_addr,
  output logic                                       resp_valid,
  output logic [X_BITS+Y_BITS+SLOT_BITS:0]           resp_paddr,
  output logic                                       resp_shared,
  output logic                                       resp_err
);
  localparam int NODE_W = X_BITS + Y_BITS;
  localparam int PA_W   = NODE_W + SLOT_BITS + 1;
  localparam int WIN_W  = SLOT_BITS + 1;

  logic [X_BITS-1:0]    col;
  logic [Y_BITS-1:0]    row;
  logic [SLOT_BITS-1:0] offset;
  logic [PA_W-1:0]      priv_pa, comm_pa, pick_pa;
  logic                 in_comm, out_of_win, accept;

  assign col        = req_node[NODE_W-1:Y_BITS];
  assign row        = req_node[Y_BITS-1:0];
  assign offset     = req_addr[SLOT_BITS-1:0];
  assign in_comm    = req_addr[SLOT_BITS];
  assign out_of_win = |req_addr[REQ_AW-1:WIN_W];
  assign accept     = req_valid && !out_of_win;

  assign priv_pa = {1'b0, col, row, offset};
  assign comm_pa = {1'b1, {NODE_W{1'b0}}, offset};
  assign pick_pa = in_comm ? comm_pa : priv_pa;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_err    <= 1'b0;
      resp_paddr  <= '0;
      resp_shared <= 1'b0;
    end else begin
      resp_valid <= accept;
      resp_err   <= req_valid && out_of_win;
      if (accept) begin
        resp_paddr  <= pick_pa;
        resp_shared <= in_comm;
      end
    end
  end
endmodule

module node_addr_map_chk #(
  parameter int X_BITS    = 2,
  parameter int Y_BITS    = 2,
  parameter int SLOT_BITS = 10,
  parameter int REQ_AW    = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic [X_BITS+Y_BITS-1:0]         req_node,
  input logic [REQ_AW-1:0]                req_addr,
  input logic                             resp_valid,
  input logic [X_BITS+Y_BITS+SLOT_BITS:0] resp_paddr,
  input logic                             resp_shared,
  input logic                             resp_err
);
  localparam int PA_W   = X_BITS + Y_BITS + SLOT_BITS + 1;
  localparam int WIN_W  = SLOT_BITS + 1;
  localparam logic [PA_W-1:0] COMM_BASE = PA_W'(1) << (PA_W - 1);
  localparam logic [PA_W-1:0] COMM_LAST = COMM_BASE + PA_W'((1 << SLOT_BITS) - 1);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(|req_addr[REQ_AW-1:WIN_W]) |=> resp_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !resp_err);
  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (|req_addr[REQ_AW-1:WIN_W]) |=> resp_err && !resp_valid);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && resp_err));
  assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_paddr <= COMM_LAST);
  assert_private_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_shared |-> resp_paddr < COMM_BASE);
  assert_common_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_shared |-> resp_paddr >= COMM_BASE);
  assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_shared == $past(req_addr[SLOT_BITS]));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid && $past(rst_n) |-> $stable(resp_paddr) && $stable(resp_shared));
endmodule

bind node_addr_map node_addr_map_chk #(
  .X_BITS(X_BITS), .Y_BITS(Y_BITS), .SLOT_BITS(SLOT_BITS), .REQ_AW(REQ_AW)
) u_chk (.*);

// File: tb/tb_node_addr_map.sv
`timescale 1ns/1ps
module tb_node_addr_map;
  typedef struct packed {
    logic [3:0]  node;
    logic [15:0] addr;
    logic [14:0] pa;
    logic        sh;
    logic        err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  16'h0000, 15'd0,     1'b0, 1'b0},
    '{4'd0,  16'h03FF, 15'd1023,  1'b0, 1'b0},
    '{4'd1,  16'h0005, 15'd1029,  1'b0, 1'b0},
    '{4'd4,  16'h0010, 15'd4112,  1'b0, 1'b0},
    '{4'd9,  16'h0200, 15'd9728,  1'b0, 1'b0},
    '{4'd15, 16'h03FF, 15'd16383, 1'b0, 1'b0},
    '{4'd6,  16'h0123, 15'd6435,  1'b0, 1'b0},
    '{4'd0,  16'h0400, 15'd16384, 1'b1, 1'b0},
    '{4'd15, 16'h0400, 15'd16384, 1'b1, 1'b0},
    '{4'd7,  16'h07FF, 15'd17407, 1'b1, 1'b0},
    '{4'd12, 16'h0455, 15'd16469, 1'b1, 1'b0},
    '{4'd3,  16'h0800, 15'd0,     1'b0, 1'b1},
    '{4'd3,  16'h8000, 15'd0,     1'b0, 1'b1},
    '{4'd10, 16'h00AB, 15'd10411, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_node = '0;
  logic [15:0] req_addr = '0;
  logic        resp_valid, resp_shared, resp_err;
  logic [14:0] resp_paddr;

  int checks = 0;
  int errors = 0;
  logic [14:0] last_pa = '0;
  logic        last_sh = 1'b0;

  always #4 clk = ~clk;

  node_addr_map dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_node(req_node),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_shared(resp_shared), .resp_err(resp_err)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_vec(input vec_t v);
    if (v.err) begin
      check("R5 err", 32'(resp_err), 1);
      check("R5 valid", 32'(resp_valid), 0);
      check("R6 hold paddr", 32'(resp_paddr), 32'(last_pa));
      check("R6 hold shared", 32'(resp_shared), 32'(last_sh));
    end else begin
      check("R2 valid", 32'(resp_valid), 1);
      check("R7 no err", 32'(resp_err), 0);
      check(v.sh ? "R4 paddr" : "R3 paddr", 32'(resp_paddr), 32'(v.pa));
      check(v.sh ? "R4 shared" : "R3 shared", 32'(resp_shared), 32'(v.sh));
      last_pa = v.pa;
      last_sh = v.sh;
    end
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(resp_valid), 0);
    check("R1 err", 32'(resp_err), 0);
    check("R1 paddr", 32'(resp_paddr), 0);
    check("R1 shared", 32'(resp_shared), 0);
    rst_n = 1'b1;

    // R8 back-to-back walk of the table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check_vec(VEC[i-1]);
      req_valid = 1'b1;
      req_node  = VEC[i].node;
      req_addr  = VEC[i].addr;
    end
    @(negedge clk);
    check_vec(VEC[NV-1]);

    // R2 / R6 idle cycle with an address on the bus
    req_valid = 1'b0;
    req_node  = 4'd5;
    req_addr  = 16'h0401;
    @(negedge clk);
    check("R2 idle valid", 32'(resp_valid), 0);
    check("R2 idle err", 32'(resp_err), 0);
    check("R6 idle paddr", 32'(resp_paddr), 32'(last_pa));

    // R5 highest stray bit, then recovery to a common result (R4)
    req_valid = 1'b1;
    req_node  = 4'd5;
    req_addr  = 16'hFFFF;
    @(negedge clk);
    check("R5 all-high err", 32'(resp_err), 1);
    check("R6 all-high hold", 32'(resp_paddr), 32'(last_pa));
    req_addr = 16'h0401;
    @(negedge clk);
    check("R4 after refuse", 32'(resp_paddr), 16385);
    check("R5 cleared", 32'(resp_err), 0);

    // R1 reset in the middle of traffic
    req_node = 4'd13;
    req_addr = 16'h0011;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid valid", 32'(resp_valid), 0);
    check("R1 mid paddr", 32'(resp_paddr), 0);
    check("R1 mid shared", 32'(resp_shared), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after reset", 32'(resp_paddr), 12288 + 1024 + 17);
    req_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule